// File: doc/BRIEF.md
# Self-Synchronizing Bit Scrambler / Descrambler

This block whitens a serial bit stream with a 7-stage shift register and two feedback taps (delays 4 and 7, polynomial 1 + z^-4 + z^-7). One core serves both directions. In scramble mode the output bit is fed back into the register. In descramble mode the received bit is fed back. Because of this, a descrambler locks onto any scrambled stream within seven bits, whatever state it starts in.

A transmitter loads a programmable seed at the start of each packet. A bypass input passes bits straight through without touching the register. The register advances only on bits marked valid. Every processed bit appears on the output one clock after it is presented.

The self-synchronizing structure has a known weakness. Some register states combined with repetitive input let the output stop looking random: all zeros into an all-zero register stays all zeros, and all ones into an all-one register stays all ones. A single bit that breaks the pattern moves the register out of such a state, and scrambling resumes.

Top module: `self_sync_scrambler`

## Requirements
- R1: After reset, `valid_o` and `bit_o` are 0 and the shift register holds all zeros.
- R2: In scramble mode (`mode_i`=0), a valid bit produces `bit_o` = `bit_i` XOR s4 XOR s7 one clock later. Here sk is the k-th most recent scrambled output bit, or the seeded value of that stage.
- R3: In descramble mode (`mode_i`=1), a valid bit produces `bit_o` = `bit_i` XOR r4 XOR r7 one clock later. Here rk is the k-th most recent received bit, or the seeded value of that stage.
- R4: A descrambler fed with a scrambler's output reproduces the scrambler's input from the eighth bit onward, whatever states the two registers start in.
- R5: With `bypass_i`=1, a valid bit appears unchanged on `bit_o` one clock later and the register does not advance. Scrambling afterwards continues as if the bypassed bits had never occurred.
- R6: `seed_load_i` loads the register so that `seed_i` bit k-1 becomes stage sk (bit 0 is the most recent stage). Any valid bit in that cycle is dropped, and `valid_o` is 0 in the following cycle.
- R7: With `valid_i`=0, `valid_o` is 0 in the following cycle, `bit_o` keeps its value, and the register holds.
- R8: Lock-up: in scramble mode, all-zero input into an all-zero register gives all-zero output, and all-one input into an all-one register gives all-one output.
- R9: Recovery: after a lock-up, a single bit that breaks the pattern makes the scrambled output differ from the repeating input within the following seven bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = scramble, 1 = descramble |
| bypass_i | input | 1 | Pass bits through unchanged, register held |
| seed_load_i | input | 1 | Load `seed_i` into the register |
| seed_i | input | 7 | Seed value, bit 0 = most recent stage |
| valid_i | input | 1 | `bit_i` is valid this cycle |
| bit_i | input | 1 | Serial input bit |
| valid_o | output | 1 | `bit_o` is valid |
| bit_o | output | 1 | Serial output bit |

## Verification
The bench builds the block with its default seven stages and taps at delays 4 and 7. A second copy is set to descramble and chained behind the first. With a register this short, every one of the 128 states can be reached directly through the seed. That lets the bench place the register straight into the all-zero and all-one lock-up states, rather than waiting for random data to land there. The chained pair shows resynchronization from mismatched seeds within the seven-bit window.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_W_DEF    = 7;
  localparam int unsigned SCR_TAP_A_DEF = 4;
  localparam int unsigned SCR_TAP_B_DEF = 7;

  typedef enum logic {
    SCR_MODE_SCRAMBLE   = 1'b0,
    SCR_MODE_DESCRAMBLE = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/scr_feedback.sv
module scr_feedback #(
  parameter int unsigned W     = 7,
  parameter int unsigned TAP_A = 4,
  parameter int unsigned TAP_B = 7
) (
  input  logic [W-1:0] state_i,
  output logic         fb_o
);
  localparam logic [W-1:0] TAP_MASK = (W'(1) << (TAP_A - 1)) | (W'(1) << (TAP_B - 1));

  logic [W:0] chain;
  assign chain[0] = 1'b0;

  // XOR chain over the selected stages
  for (genvar k = 0; k < W; k++) begin : g_tap
    if (TAP_MASK[k]) begin : g_on
      assign chain[k+1] = chain[k] ^ state_i[k];
    end else begin : g_off
      assign chain[k+1] = chain[k];
    end
  end

  assign fb_o = chain[W];
endmodule

// File: rtl/scr_shift_reg.sv
module scr_shift_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  input  logic         in_bit_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (load_i) begin
      state_q <= seed_i;
    end else if (adv_i) begin
      state_q <= {state_q[W-2:0], in_bit_i};
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/self_sync_scrambler.sv
module self_sync_scrambler #(
  parameter int unsigned W     = scr_pkg::SCR_W_DEF,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A_DEF,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         bypass_i,
  input  logic         seed_load_i,
  input  logic [W-1:0] seed_i,
  input  logic         valid_i,
  input  logic         bit_i,
  output logic         valid_o,
  output logic         bit_o
);
  import scr_pkg::*;

  scr_mode_e    mode;
  logic [W-1:0] state_q;
  logic         fb;
  logic         mixed;
  logic         fed_bit;
  logic         out_next;
  logic         accept;
  logic         adv;

  assign mode     = scr_mode_e'(mode_i);
  assign accept   = valid_i & ~seed_load_i;
  assign adv      = accept & ~bypass_i;
  assign mixed    = bit_i ^ fb;
  assign out_next = bypass_i ? bit_i : mixed;
  // scramble feeds back its output, descramble feeds back the line bit
  assign fed_bit  = (mode == SCR_MODE_DESCRAMBLE) ? bit_i : mixed;

  scr_feedback #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_fb (
    .state_i (state_q),
    .fb_o    (fb)
  );

  scr_shift_reg #(.W(W)) u_sr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (seed_load_i),
    .seed_i   (seed_i),
    .adv_i    (adv),
    .in_bit_i (fed_bit),
    .state_o  (state_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= accept;
      if (accept) bit_o <= out_next;
    end
  end
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
  parameter int unsigned W = 7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_i,
  input logic         bypass_i,
  input logic         seed_load_i,
  input logic [W-1:0] seed_i,
  input logic         valid_i,
  input logic         bit_i,
  input logic         valid_o,
  input logic         bit_o,
  input logic [W-1:0] state_q
);
  // R6
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> (state_q == $past(seed_i)) && !valid_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !seed_load_i) |=> !valid_o && $stable(state_q) && $stable(bit_o));

  // R5
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bypass_i && !seed_load_i) |=>
      valid_o && (bit_o == $past(bit_i)) && $stable(state_q));

  // R2
  scr_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bypass_i && !seed_load_i && !mode_i) |=>
      valid_o && (state_q[0] == bit_o) && (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R3
  dscr_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bypass_i && !seed_load_i && mode_i) |=>
      valid_o && (state_q[0] == $past(bit_i)) && (state_q[W-1:1] == $past(state_q[W-2:0])));
endmodule

bind self_sync_scrambler scr_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .bypass_i    (bypass_i),
  .seed_load_i (seed_load_i),
  .seed_i      (seed_i),
  .valid_i     (valid_i),
  .bit_i       (bit_i),
  .valid_o     (valid_o),
  .bit_o       (bit_o),
  .state_q     (state_q)
);

// File: tb/self_sync_scrambler_tb_top.sv
module self_sync_scrambler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 7;
  localparam int NVEC = 24;
  // {mode, bypass, bit}
  localparam logic [2:0] VEC [0:NVEC-1] = '{
    3'b001, 3'b000, 3'b001, 3'b001, 3'b000, 3'b001, 3'b011, 3'b010,
    3'b001, 3'b000, 3'b000, 3'b001, 3'b101, 3'b100, 3'b101, 3'b111,
    3'b101, 3'b100, 3'b100, 3'b101, 3'b001, 3'b011, 3'b001, 3'b000
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b0, bypass_i = 1'b0, seed_load_i = 1'b0, valid_i = 1'b0, bit_i = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic valid_o, bit_o;
  logic d_seed_load = 1'b0;
  logic [W-1:0] d_seed = '0;
  logic d_valid_o, d_bit_o;

  int checks = 0, errors = 0;
  logic [W-1:0] ref_st = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  self_sync_scrambler dut_i (
    .clk_i, .rst_ni, .mode_i, .bypass_i, .seed_load_i, .seed_i,
    .valid_i, .bit_i, .valid_o, .bit_o
  );

  self_sync_scrambler desc_i (
    .clk_i, .rst_ni, .mode_i(1'b1), .bypass_i(1'b0), .seed_load_i(d_seed_load),
    .seed_i(d_seed), .valid_i(valid_o), .bit_i(bit_o),
    .valid_o(d_valid_o), .bit_o(d_bit_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // one bit through the DUT, checked against the bench model
  task automatic step(input logic m, input logic byp, input logic b, input string req,
                      output logic got);
    logic f, e;
    mode_i = m; bypass_i = byp; bit_i = b; valid_i = 1'b1;
    f = ref_st[3] ^ ref_st[6];
    e = byp ? b : (b ^ f);
    if (!byp) ref_st = {ref_st[W-2:0], m ? b : e};
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, valid_o, 1'b1);
    chk(req, bit_o, e);
    got = bit_o;
  endtask

  task automatic load(input logic [W-1:0] s);
    seed_i = s; seed_load_i = 1'b1; valid_i = 1'b1; bit_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    seed_load_i = 1'b0; valid_i = 1'b0;
    ref_st = s;
    chk("R6 valid dropped", valid_o, 1'b0);
  endtask

  initial begin
    logic g, held, diff;
    logic hist [0:63];
    #(CLK_PERIOD*3);
    @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", valid_o, 1'b0);
    chk("R1 bit", bit_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b0, 1'b0, 1'b0, "R1 zero state", g);

    // R2/R3/R5 table walk
    load(7'h35);
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][2], VEC[i][1], VEC[i][0], VEC[i][1] ? "R5 bypass" : (VEC[i][2] ? "R3 descramble" : "R2 scramble"), g);

    // R7 idle: output holds, valid low, state unchanged
    held = bit_o;
    repeat (3) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R7 valid low", valid_o, 1'b0);
      chk("R7 bit hold", bit_o, held);
    end
    step(1'b0, 1'b0, 1'b1, "R7 state held", g);

    // R6 seed bit positions
    for (int k = 0; k < W; k++) begin
      load(W'(1) << k);
      step(1'b0, 1'b0, 1'b0, "R6 seed position", g);
    end

    // R8 lock-up, all zeros
    load('0);
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b0, 1'b0, "R8 zeros", g);
      chk("R8 zeros out", g, 1'b0);
    end
    // R9 break then repeat zeros
    step(1'b0, 1'b0, 1'b1, "R9 break", g);
    diff = 1'b0;
    for (int i = 0; i < 7; i++) begin
      step(1'b0, 1'b0, 1'b0, "R9 recover", g);
      diff |= g;
    end
    chk("R9 output leaves zeros", diff, 1'b1);

    // R8 lock-up, all ones
    load('1);
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b0, 1'b1, "R8 ones", g);
      chk("R8 ones out", g, 1'b1);
    end
    step(1'b0, 1'b0, 1'b0, "R9 break", g);
    diff = 1'b0;
    for (int i = 0; i < 7; i++) begin
      step(1'b0, 1'b0, 1'b1, "R9 recover", g);
      diff |= ~g;
    end
    chk("R9 output leaves ones", diff, 1'b1);

    // R4 chained round trip from mismatched seeds
    d_seed = 7'h4B; d_seed_load = 1'b1;
    load(7'h12);
    d_seed_load = 1'b0;
    for (int i = 0; i < 40; i++) begin
      hist[i] = logic'((i * 37 + i / 3) % 5 < 2);
      step(1'b0, 1'b0, hist[i], "R4 scramble", g);
      if (i >= 8) begin
        chk("R4 desc valid", d_valid_o, 1'b1);
        chk("R4 round trip", d_bit_o, hist[i-1]);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule